// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Fetcher

This block keeps a network receive DMA engine supplied with empty buffers. The host places buffer descriptors in a ring in its own memory. The block reads them one at a time over a simple request/response memory port and hands each buffer pointer to the receive datapath over a valid/ready handshake. The ring can be refilled in one of two ways, and a configuration input selects which.

In counted mode, the host posts descriptors and then writes the new producer position into the block. The block delivers buffers only while the producer is ahead of its own consumer position. It raises a sticky low-buffer interrupt when the number of posted buffers drops under a programmable threshold, or when it reaches zero. In polling mode, the producer value has no meaning. The block fetches the next descriptor unconditionally and accepts it only if its valid flag is set. On an invalid descriptor, the block raises the interrupt and parks. Any producer write then makes it fetch the same slot again. A descriptor carrying the end flag sends the next fetch back to the ring start. The ring also wraps by itself at its full size.

Descriptors are one 32-bit word: bit 0 is the valid flag, bit 1 is the end flag, and bits 31:2 are the word-aligned buffer address. A configurable number of words of host-private data may follow each descriptor.

Top module: `rxq_fetch_ctrl`

## Requirements
- R1: After reset, mem_req, buf_valid and irq_low are 0 and cons_idx is 0.
- R2: After reset, no fetch is issued until a producer write arrives with prod_dma_en = 1. Producer writes with prod_dma_en = 0 do not start the block.
- R3: A fetch address is the ring base with its low 8 bits forced to zero, plus cons_idx × (DESC_WORDS + cfg_skip) × 4 bytes.
- R4: In counted mode (cfg_poll = 0), exactly (producer − consumer) mod ring size buffers are delivered. Fetching then stops until the producer moves, and the valid and end flags are ignored.
- R5: In counted mode, once started, irq_low is set in any cycle where the outstanding count is below cfg_thresh or is zero. irq_low then stays set until a cycle with irq_clr = 1 in which the set condition is false.
- R6: In polling mode, a descriptor with bit 0 set is handed out as buf_addr with bits 1:0 cleared, whatever value the producer holds.
- R7: In polling mode, a descriptor with bit 0 clear sets irq_low and causes no further fetch until a producer write of any value. That write refetches the same address.
- R8: In polling mode, an accepted descriptor with bit 1 set makes the next fetch use the ring base, and cons_idx becomes 0.
- R9: In polling mode with no end flag, the fetch after the last slot of the ring uses the ring base.
- R10: cfg_big selects a ring of 2048 entries (1) or 256 entries (0). The producer value and cons_idx are taken modulo that size.
- R11: At most one fetch is outstanding: mem_req stays low from grant until the response arrives.
- R12: While buf_valid is high and buf_ready is low, buf_valid and buf_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_poll | input | 1 | 1 = polling mode, 0 = counted mode |
| cfg_big | input | 1 | Ring size: 1 = 2048 entries, 0 = 256 entries |
| cfg_base | input | ADDR_W | Ring base address (low 8 bits ignored) |
| cfg_skip | input | SKIP_W | Words skipped after each descriptor |
| cfg_thresh | input | IDX_W | Low-buffer threshold for counted mode |
| prod_wr | input | 1 | Producer register write strobe |
| prod_wdata | input | IDX_W | Producer position written by the host |
| prod_dma_en | input | 1 | Enable bit carried with the producer write |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | ADDR_W | Descriptor read address |
| mem_gnt | input | 1 | Request accepted by memory |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | ADDR_W | Descriptor word |
| buf_valid | output | 1 | Buffer pointer offered to the datapath |
| buf_addr | output | ADDR_W | Buffer address |
| buf_ready | input | 1 | Datapath takes the buffer |
| cons_idx | output | IDX_W | Current consumer slot |
| irq_low | output | 1 | Sticky low-buffer interrupt status |
| irq_clr | input | 1 | Write-one-to-clear strobe for irq_low |

## Verification
The bound checker checks, on every cycle, the properties that need no memory contents. These are: the single-outstanding-fetch rule, the hold of the buffer handshake, silence on the memory port before the start write, silence while parked on an invalid descriptor, the stickiness of irq_low, and the range of cons_idx in the small ring. The bench's scenarios cover the rest, which depends on what the host put in memory and wrote to the producer. That means exact fetch addresses under different skip counts, the number of buffers delivered in counted mode, wrap on the end flag and at the ring size, masking of the producer value, and refetch after a producer write.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [2:0] {
    FS_IDLE  = 3'd0,
    FS_REQ   = 3'd1,
    FS_WAIT  = 3'd2,
    FS_HAND  = 3'd3,
    FS_STALL = 3'd4
  } fetch_st_e;

  localparam int unsigned WORD_BYTES_LG = 2;
  localparam int unsigned BASE_ALIGN_W  = 8;
  localparam int unsigned FLAG_VALID    = 0;
  localparam int unsigned FLAG_END      = 1;

endpackage

// File: rtl/rxq_idx_track.sv
module rxq_idx_track #(
  parameter int unsigned IDX_W   = 11,
  parameter int unsigned SMALL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_big,
  input  logic             prod_wr,
  input  logic [IDX_W-1:0] prod_wdata,
  input  logic             adv,
  input  logic             wrap_zero,
  output logic [IDX_W-1:0] cons_idx,
  output logic [IDX_W-1:0] avail
);

  localparam logic [IDX_W-1:0] SMALL_MASK = IDX_W'((1 << SMALL_W) - 1);

  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] prod_q, prod_n;
  logic [IDX_W-1:0] cons_q, cons_n;
  logic             prod_en, cons_en;

  always_comb begin
    mask    = cfg_big ? {IDX_W{1'b1}} : SMALL_MASK;
    prod_en = prod_wr;
    prod_n  = prod_wdata & mask;
    cons_en = adv;
    if (wrap_zero) cons_n = '0;
    else           cons_n = (cons_q + 1'b1) & mask;
    avail   = (prod_q - cons_q) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (prod_en) prod_q <= prod_n;
      if (cons_en) cons_q <= cons_n;
    end
  end

  assign cons_idx = cons_q;

endmodule

// File: rtl/rxq_addr_gen.sv
module rxq_addr_gen import rxq_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IDX_W      = 11,
  parameter int unsigned SKIP_W     = 4,
  parameter int unsigned DESC_WORDS = 1
) (
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] fetch_addr
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << BASE_ALIGN_W) - 1);

  logic [ADDR_W-1:0] base_al;
  logic [ADDR_W-1:0] stride_b;
  logic [ADDR_W-1:0] offset;

  generate
    if (DESC_WORDS == 1) begin : g_unit
      always_comb stride_b = (ADDR_W'(cfg_skip) + ADDR_W'(1)) << WORD_BYTES_LG;
    end else begin : g_multi
      always_comb stride_b = (ADDR_W'(cfg_skip) + ADDR_W'(DESC_WORDS)) << WORD_BYTES_LG;
    end
  endgenerate

  always_comb begin
    base_al    = cfg_base & ALIGN_MASK;
    offset     = ADDR_W'(idx) * stride_b;
    fetch_addr = base_al + offset;
  end

endmodule

// File: rtl/rxq_low_irq.sv
module rxq_low_irq #(
  parameter int unsigned IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             cfg_poll,
  input  logic [IDX_W-1:0] avail,
  input  logic [IDX_W-1:0] cfg_thresh,
  input  logic             empty_evt,
  input  logic             irq_clr,
  output logic             irq_low
);

  logic irq_q, irq_n, irq_en;
  logic set_cnt, set_any;

  always_comb begin
    set_cnt = (avail < cfg_thresh) || (avail == '0);
    set_any = running && (cfg_poll ? empty_evt : set_cnt);
    irq_en  = set_any || irq_clr;
    irq_n   = set_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_n;
  end

  assign irq_low = irq_q;

endmodule

// File: rtl/rxq_fetch_ctrl.sv
module rxq_fetch_ctrl import rxq_pkg::*; #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IDX_W      = 11,
  parameter int unsigned SMALL_W    = 8,
  parameter int unsigned SKIP_W     = 4,
  parameter int unsigned DESC_WORDS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_poll,
  input  logic              cfg_big,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [SKIP_W-1:0] cfg_skip,
  input  logic [IDX_W-1:0]  cfg_thresh,
  input  logic              prod_wr,
  input  logic [IDX_W-1:0]  prod_wdata,
  input  logic              prod_dma_en,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  output logic              buf_valid,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic              buf_ready,
  output logic [IDX_W-1:0]  cons_idx,
  output logic              irq_low,
  input  logic              irq_clr
);

  localparam logic [ADDR_W-1:0] PTR_MASK = ~ADDR_W'((1 << WORD_BYTES_LG) - 1);

  fetch_st_e         st_q, st_n;
  logic              run_q, run_n, run_en;
  logic [ADDR_W-1:0] buf_q, buf_n;
  logic              end_q, end_n;
  logic              hold_en;
  logic              adv, wrap_zero, empty_evt;
  logic [IDX_W-1:0]  avail;
  logic [ADDR_W-1:0] fetch_addr;
  logic              desc_ok;

  rxq_idx_track #(
    .IDX_W   (IDX_W),
    .SMALL_W (SMALL_W)
  ) u_idx (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_big    (cfg_big),
    .prod_wr    (prod_wr),
    .prod_wdata (prod_wdata),
    .adv        (adv),
    .wrap_zero  (wrap_zero),
    .cons_idx   (cons_idx),
    .avail      (avail)
  );

  rxq_addr_gen #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .SKIP_W     (SKIP_W),
    .DESC_WORDS (DESC_WORDS)
  ) u_addr (
    .cfg_base   (cfg_base),
    .cfg_skip   (cfg_skip),
    .idx        (cons_idx),
    .fetch_addr (fetch_addr)
  );

  rxq_low_irq #(
    .IDX_W (IDX_W)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (run_q),
    .cfg_poll   (cfg_poll),
    .avail      (avail),
    .cfg_thresh (cfg_thresh),
    .empty_evt  (empty_evt),
    .irq_clr    (irq_clr),
    .irq_low    (irq_low)
  );

  // next-state logic
  always_comb begin
    st_n      = st_q;
    adv       = 1'b0;
    wrap_zero = 1'b0;
    empty_evt = 1'b0;
    hold_en   = 1'b0;
    desc_ok   = !cfg_poll || mem_rsp_data[FLAG_VALID];
    run_en    = prod_wr && prod_dma_en;
    run_n     = 1'b1;
    buf_n     = mem_rsp_data & PTR_MASK;
    end_n     = cfg_poll && mem_rsp_data[FLAG_END];
    unique case (st_q)
      FS_IDLE: begin
        if (run_q && (cfg_poll || (avail != '0))) st_n = FS_REQ;
      end
      FS_REQ: begin
        if (mem_gnt) st_n = FS_WAIT;
      end
      FS_WAIT: begin
        if (mem_rsp_valid) begin
          if (desc_ok) begin
            hold_en = 1'b1;
            st_n    = FS_HAND;
          end else begin
            empty_evt = 1'b1;
            st_n      = prod_wr ? FS_IDLE : FS_STALL;
          end
        end
      end
      FS_HAND: begin
        if (buf_ready) begin
          adv       = 1'b1;
          wrap_zero = end_q;
          st_n      = FS_IDLE;
        end
      end
      FS_STALL: begin
        if (prod_wr) st_n = FS_IDLE;
      end
      default: st_n = FS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FS_IDLE;
      run_q <= 1'b0;
      buf_q <= '0;
      end_q <= 1'b0;
    end else begin
      st_q <= st_n;
      if (run_en) run_q <= run_n;
      if (hold_en) begin
        buf_q <= buf_n;
        end_q <= end_n;
      end
    end
  end

  assign mem_req   = (st_q == FS_REQ);
  assign mem_addr  = fetch_addr;
  assign buf_valid = (st_q == FS_HAND);
  assign buf_addr  = buf_q;

endmodule

// File: rtl/rxq_fetch_ctrl_chk.sv
module rxq_fetch_ctrl_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 11,
  parameter int unsigned SMALL_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_poll,
  input logic              cfg_big,
  input logic              prod_wr,
  input logic              prod_dma_en,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_rsp_valid,
  input logic [ADDR_W-1:0] mem_rsp_data,
  input logic              buf_valid,
  input logic [ADDR_W-1:0] buf_addr,
  input logic              buf_ready,
  input logic [IDX_W-1:0]  cons_idx,
  input logic              irq_low,
  input logic              irq_clr
);

  logic pend_q, started_q, parked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      started_q <= 1'b0;
      parked_q  <= 1'b0;
    end else begin
      if (mem_req && mem_gnt) pend_q <= 1'b1;
      else if (mem_rsp_valid) pend_q <= 1'b0;
      if (prod_wr && prod_dma_en) started_q <= 1'b1;
      if (prod_wr) parked_q <= 1'b0;
      else if (mem_rsp_valid && cfg_poll && !mem_rsp_data[0]) parked_q <= 1'b1;
    end
  end

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !mem_req);

  assert_hand_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_valid && !buf_ready) |=> (buf_valid && $stable(buf_addr)));

  assert_quiet_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> !mem_req);

  assert_parked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    parked_q |-> !mem_req);

  assert_irq_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_low && !irq_clr) |=> irq_low);

  assert_small_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_big |-> (cons_idx < IDX_W'(1 << SMALL_W)));

endmodule

bind rxq_fetch_ctrl rxq_fetch_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .IDX_W   (IDX_W),
  .SMALL_W (SMALL_W)
) u_chk (.*);

// File: tb/tb_rxq_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_rxq_fetch_ctrl;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned IDX_W  = 11;
  localparam int unsigned SKIP_W = 4;

  logic              clk;
  logic              rst_n;
  logic              cfg_poll, cfg_big;
  logic [ADDR_W-1:0] cfg_base;
  logic [SKIP_W-1:0] cfg_skip;
  logic [IDX_W-1:0]  cfg_thresh;
  logic              prod_wr;
  logic [IDX_W-1:0]  prod_wdata;
  logic              prod_dma_en;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_gnt;
  logic              mem_rsp_valid;
  logic [ADDR_W-1:0] mem_rsp_data;
  logic              buf_valid;
  logic [ADDR_W-1:0] buf_addr;
  logic              buf_ready;
  logic [IDX_W-1:0]  cons_idx;
  logic              irq_low;
  logic              irq_clr;

  rxq_fetch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_poll(cfg_poll), .cfg_big(cfg_big),
    .cfg_base(cfg_base), .cfg_skip(cfg_skip), .cfg_thresh(cfg_thresh),
    .prod_wr(prod_wr), .prod_wdata(prod_wdata), .prod_dma_en(prod_dma_en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_ready(buf_ready),
    .cons_idx(cons_idx), .irq_low(irq_low), .irq_clr(irq_clr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int req_cnt = 0;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] fetch_q[$];
  logic [31:0] hand_q[$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory model and monitor: sample at negedge, respond at next posedge
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      logic        take;
      logic [31:0] dat;
      @(negedge clk);
      take = rst_n && mem_req && mem_gnt;
      dat  = 32'h0;
      if (take) begin
        fetch_q.push_back(mem_addr);
        req_cnt++;
        dat = rd(mem_addr);
      end
      if (rst_n && buf_valid && buf_ready) hand_q.push_back(buf_addr);
      @(posedge clk);
      mem_rsp_valid <= take;
      mem_rsp_data  <= dat;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic poll, input logic big, input logic [31:0] base,
                          input logic [3:0] skip, input logic [10:0] thr);
    step();
    rst_n = 1'b0;
    cfg_poll = poll; cfg_big = big; cfg_base = base; cfg_skip = skip; cfg_thresh = thr;
    prod_wr = 1'b0; prod_wdata = '0; prod_dma_en = 1'b0;
    buf_ready = 1'b1; irq_clr = 1'b0; mem_gnt = 1'b1;
    repeat (3) step();
    fetch_q.delete();
    hand_q.delete();
    req_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic prod_write(input logic [10:0] v, input logic en);
    step();
    prod_wr = 1'b1; prod_wdata = v; prod_dma_en = en;
    step();
    prod_wr = 1'b0; prod_dma_en = 1'b0;
  endtask

  task automatic clr_pulse();
    step();
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_hands(input int n, input int limit, input string req);
    int c = 0;
    while (hand_q.size() < n && c < limit) begin
      @(negedge clk);
      c++;
    end
    chk(req, hand_q.size(), n);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0, 32'h0, 4'd0, 11'd0);
    @(negedge clk);
    chk("R1 mem_req", mem_req, 0);
    chk("R1 buf_valid", buf_valid, 0);
    chk("R1 irq_low", irq_low, 0);
    chk("R1 cons_idx", cons_idx, 0);
  endtask

  task automatic t_poll_basic();
    logic [31:0] b = 32'h1000_0000;
    do_reset(1'b1, 1'b0, b, 4'd1, 11'd0);
    for (int i = 0; i < 4; i++) mem[b + i*8] = 32'hA000_0000 + i*32'h100 + 32'h1;
    mem[b + 32] = 32'h0;
    repeat (20) step();
    chk("R2 idle before start", req_cnt, 0);
    prod_write(11'd7, 1'b0);
    repeat (10) step();
    chk("R2 write without enable", req_cnt, 0);
    prod_write(11'd0, 1'b1);
    repeat (60) step();
    @(negedge clk);
    chk("R6 hand count", hand_q.size(), 4);
    for (int i = 0; i < 4; i++) chk("R6 buffer addr", hand_q[i], 32'hA000_0000 + i*32'h100);
    chk("R7 fetch count", fetch_q.size(), 5);
    for (int i = 0; i < 5; i++) chk("R3 fetch addr skip1", fetch_q[i], b + i*8);
    chk("R7 irq on empty", irq_low, 1);
    chk("R7 cons", cons_idx, 4);
    repeat (30) step();
    chk("R7 parked", req_cnt, 5);
    clr_pulse();
    chk("R7 irq cleared", irq_low, 0);
    mem[b + 32] = 32'hC000_0003;
    mem[b]      = 32'h0;
    prod_write(11'h5A, 1'b0);
    repeat (40) step();
    @(negedge clk);
    chk("R7 refetch count", fetch_q.size(), 7);
    chk("R7 refetch same slot", fetch_q[5], b + 32);
    chk("R8 end desc handed", hand_q[4], 32'hC000_0000);
    chk("R8 wrap to base", fetch_q[6], b);
    chk("R8 cons zero", cons_idx, 0);
    chk("R7 irq again", irq_low, 1);
  endtask

  task automatic t_poll_wrap();
    logic [31:0] b = 32'h2000_0000;
    do_reset(1'b1, 1'b0, b + 32'h55, 4'd0, 11'd0);
    for (int i = 0; i < 256; i++) mem[b + i*4] = 32'hD000_0000 + i*16 + 1;
    prod_write(11'd0, 1'b1);
    wait_hands(257, 4000, "R9 hand count");
    chk("R3 base aligned", fetch_q[0], b);
    chk("R9 last slot", fetch_q[255], b + 32'h3FC);
    chk("R9 wrap at size", fetch_q[256], b);
    chk("R9 wrapped buffer", hand_q[256], 32'hD000_0000);
  endtask

  task automatic t_normal();
    logic [31:0] b = 32'h3000_0000;
    do_reset(1'b0, 1'b0, b, 4'd2, 11'd4);
    for (int i = 0; i < 256; i++) mem[b + i*12] = 32'hB000_0000 + i*16;
    @(negedge clk);
    chk("R5 no irq before start", irq_low, 0);
    prod_write(11'd3, 1'b1);
    repeat (40) step();
    @(negedge clk);
    chk("R4 three delivered", hand_q.size(), 3);
    chk("R4 stops", req_cnt, 3);
    chk("R3 fetch addr skip2", fetch_q[2], b + 24);
    chk("R4 valid flag ignored", hand_q[2], 32'hB000_0020);
    chk("R5 irq below thresh", irq_low, 1);
    chk("R4 cons", cons_idx, 3);
    clr_pulse();
    chk("R5 re-raised while low", irq_low, 1);
    buf_ready = 1'b0;
    prod_write(11'd10, 1'b1);
    repeat (20) step();
    @(negedge clk);
    chk("R12 offer held", buf_valid, 1);
    chk("R12 addr held", buf_addr, 32'hB000_0030);
    chk("R11 no fetch ahead", req_cnt, 4);
    clr_pulse();
    chk("R5 cleared above thresh", irq_low, 0);
    step();
    buf_ready = 1'b1;
    wait_hands(10, 200, "R4 ten delivered");
    repeat (10) step();
    @(negedge clk);
    chk("R4 fetch total", req_cnt, 10);
    chk("R5 irq after drain", irq_low, 1);
    chk("R4 cons ten", cons_idx, 10);
    prod_write(11'd254, 1'b1);
    wait_hands(254, 3000, "R4 run to 254");
    repeat (10) step();
    @(negedge clk);
    chk("R10 cons 254", cons_idx, 254);
    chk("R4 no extra", req_cnt, 254);
    prod_write(11'h102, 1'b1);
    wait_hands(258, 200, "R10 masked producer");
    repeat (10) step();
    @(negedge clk);
    chk("R10 count after wrap", fetch_q.size(), 258);
    chk("R10 slot 254", fetch_q[254], b + 254*12);
    chk("R10 wrap to base", fetch_q[256], b);
    chk("R10 slot 1", fetch_q[257], b + 12);
    chk("R10 cons wrapped", cons_idx, 2);
  endtask

  task automatic t_big();
    logic [31:0] b = 32'h4000_0000;
    do_reset(1'b0, 1'b1, b, 4'd0, 11'd0);
    prod_write(11'd300, 1'b1);
    repeat (20) step();
    @(negedge clk);
    chk("R5 no irq with buffers", irq_low, 0);
    wait_hands(300, 3000, "R10 big ring count");
    repeat (10) step();
    @(negedge clk);
    chk("R10 cons past 255", cons_idx, 300);
    chk("R10 big slot 299", fetch_q[299], b + 299*4);
    chk("R5 irq at zero", irq_low, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog all-R actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_poll = 1'b0; cfg_big = 1'b0; cfg_base = '0; cfg_skip = '0; cfg_thresh = '0;
    prod_wr = 1'b0; prod_wdata = '0; prod_dma_en = 1'b0;
    buf_ready = 1'b1; irq_clr = 1'b0; mem_gnt = 1'b1;
    t_reset();
    t_poll_basic();
    t_poll_wrap();
    t_normal();
    t_big();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule